// File: doc/BRIEF.md
# DMA Single-Transfer Bus Sequencer

This block carries out one DMA move on a shared external bus after the CPU side has handed the bus over. A request gives a source address, a destination address and a size, which is either a byte or a 16-bit word. Once the request is accepted, the block raises a hold signal and lets one idle cycle pass. It then runs every bus cycle that the source read needs, followed by every bus cycle that the destination write needs. The read data is kept in an internal buffer and is driven back out during the write.

Each access takes its timing from the area its address falls in. The top bits of the address select one of eight areas. Two configuration vectors tell, for each area, whether its data bus is 8 or 16 bits wide and whether its cycles have two or three states. A word that goes to an 8-bit area is split into two byte cycles. When the write ends, the block drops its hold signal, pulses done, and waits to see the grant go low before it will take another request.

Top module: `dmaBusSeq`

## Requirements
- R1: While reset is held and in the first cycle after it, busHold, done, rdStrobe, hwrStrobe and lwrStrobe are low, and addr is zero.
- R2: A request is taken when reqValid and busGrant are both high in the idle state. The next cycle is a dead cycle: busHold is high and no strobe is active. The first access T1 state follows that dead cycle.
- R3: Every source read cycle finishes before the first destination write cycle begins. rdStrobe is high only in the T2 and T3 states of read cycles.
- R4: The area is addr[23:21]. Bit n of areaWide set to 1 means area n has a 16-bit bus, and 0 means 8-bit. Bit n of areaThree set to 1 means cycles in area n have the three states T1, T2 and T3, and 0 means two states (T1, T2).
- R5: A word access to a 16-bit area is one bus cycle at the even address (bit 0 cleared). Data uses all 16 lines, with the even byte on [15:8], and a write asserts both hwrStrobe and lwrStrobe.
- R6: A word access to an 8-bit area is two bus cycles: the even address first, carrying the upper (even) byte, then address+1 carrying the lower byte. The data uses lines [15:8], and a write asserts only hwrStrobe.
- R7: A byte transfer is one read cycle and one write cycle at the given address. In a 16-bit area, an even address uses lines [15:8] and hwrStrobe, and an odd address uses lines [7:0] and lwrStrobe. In an 8-bit area the byte always uses [15:8] and hwrStrobe.
- R8: busHold stays high without a break from the dead cycle through the last write state, even if busGrant falls during the transfer.
- R9: In the cycle after the last write state, busHold is low and done is high, for exactly one cycle.
- R10: After done, no new request is taken until busGrant has been seen low. While busGrant stays high, reqValid has no effect.
- R11: hwrStrobe and lwrStrobe are high only in the T2 and T3 states of write cycles. addr does not change while any strobe is high. A read strobe and a write strobe are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| reqValid | input | 1 | Transfer request |
| reqSrc | input | 24 | Source address |
| reqDst | input | 24 | Destination address |
| reqWord | input | 1 | 1 = word transfer, 0 = byte transfer |
| busGrant | input | 1 | Bus granted to the DMA side |
| areaWide | input | 8 | Per-area bus width, 1 = 16-bit |
| areaThree | input | 8 | Per-area state count, 1 = three states |
| rdData | input | 16 | Read data from the bus |
| busHold | output | 1 | Block owns the bus |
| addr | output | 24 | Bus address |
| rdStrobe | output | 1 | Read strobe, active high |
| hwrStrobe | output | 1 | High-byte write strobe, active high |
| lwrStrobe | output | 1 | Low-byte write strobe, active high |
| wrData | output | 16 | Write data |
| done | output | 1 | One-cycle completion pulse |

## Verification
A state counter that is off by one shows up in the first bus cycle. The strobe would rise in T1 or run into an extra T3, and the cycle-by-cycle comparison of addr and the strobes would catch it at once. A wrong sub-cycle index or a wrong lane choice in the buffer appears as a bad address or a bad byte on the active lanes during the write. That is at most a dozen cycles after acceptance. A hold or handover fault shows as a gap in busHold, a missing or stretched done, or an accepted request while the grant is still high. Each of these is visible within one or two cycles of the point where it goes wrong.

// File: rtl/dmaSeqPkg.sv
package dmaSeqPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEAD,
    ST_READ,
    ST_WRITE,
    ST_DONE,
    ST_REL
  } seqState_t;

  // Controls passed from the sequencer to the datapath
  typedef struct packed {
    logic latchReq;  // take the request into the registers
    logic active;    // a bus cycle is in progress
    logic isWrite;   // the current cycle is a write
    logic subIdx;    // which byte cycle of a split word
    logic strobe;    // T2 or T3 state
    logic capture;   // last state of a read cycle
  } seqCtl_t;

endpackage

// File: rtl/dmaSeqCtrl.sv
module dmaSeqCtrl
  import dmaSeqPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    busGrant,
  input  logic    xferWord,
  input  logic    srcWide,
  input  logic    srcThree,
  input  logic    dstWide,
  input  logic    dstThree,
  output seqCtl_t ctl,
  output logic    busHold,
  output logic    done
);

  seqState_t state;
  logic [1:0] tCnt;
  logic       subIdx;

  logic inRead, inWrite, curWide, curThree, twoCycles, endOfCycle, lastCycle;
  logic [1:0] lastT;

  always_comb begin
    inRead     = (state == ST_READ);
    inWrite    = (state == ST_WRITE);
    curWide    = inWrite ? dstWide : srcWide;
    curThree   = inWrite ? dstThree : srcThree;
    lastT      = curThree ? 2'd2 : 2'd1;
    twoCycles  = xferWord && !curWide;
    endOfCycle = (inRead || inWrite) && (tCnt == lastT);
    lastCycle  = !twoCycles || subIdx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      tCnt   <= 2'd0;
      subIdx <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (reqValid && busGrant) state <= ST_DEAD;
        ST_DEAD: begin
          state  <= ST_READ;
          tCnt   <= 2'd0;
          subIdx <= 1'b0;
        end
        ST_READ, ST_WRITE: begin
          if (endOfCycle) begin
            tCnt <= 2'd0;
            if (lastCycle) begin
              subIdx <= 1'b0;
              state  <= inRead ? ST_WRITE : ST_DONE;
            end else begin
              subIdx <= 1'b1;
            end
          end else begin
            tCnt <= tCnt + 2'd1;
          end
        end
        ST_DONE: state <= ST_REL;
        ST_REL:  if (!busGrant) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.latchReq = (state == ST_IDLE) && reqValid && busGrant;
    ctl.active   = inRead || inWrite;
    ctl.isWrite  = inWrite;
    ctl.subIdx   = subIdx;
    ctl.strobe   = (inRead || inWrite) && (tCnt != 2'd0);
    ctl.capture  = inRead && endOfCycle;
    busHold      = (state == ST_DEAD) || inRead || inWrite;
    done         = (state == ST_DONE);
  end

endmodule

// File: rtl/dmaSeqPath.sv
module dmaSeqPath
  import dmaSeqPkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int AREA_BITS = 3,
  localparam int NUM_AREAS = 1 << AREA_BITS
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  seqCtl_t              ctl,
  input  logic [ADDR_W-1:0]    reqSrc,
  input  logic [ADDR_W-1:0]    reqDst,
  input  logic                 reqWord,
  input  logic [NUM_AREAS-1:0] areaWide,
  input  logic [NUM_AREAS-1:0] areaThree,
  input  logic [15:0]          rdData,
  output logic                 xferWord,
  output logic                 srcWide,
  output logic                 srcThree,
  output logic                 dstWide,
  output logic                 dstThree,
  output logic [ADDR_W-1:0]    addr,
  output logic                 rdStrobe,
  output logic                 hwrStrobe,
  output logic                 lwrStrobe,
  output logic [15:0]          wrData
);

  logic [ADDR_W-1:0] srcReg, dstReg;
  logic [15:0]       dataBuf;

  logic [AREA_BITS-1:0] srcArea, dstArea;
  logic [ADDR_W-1:0]    baseAddr;
  logic                 curWide, oddByte;
  logic [7:0]           readByte, writeByte;

  always_comb begin
    srcArea  = srcReg[ADDR_W-1 -: AREA_BITS];
    dstArea  = dstReg[ADDR_W-1 -: AREA_BITS];
    srcWide  = areaWide[srcArea];
    srcThree = areaThree[srcArea];
    dstWide  = areaWide[dstArea];
    dstThree = areaThree[dstArea];
  end

  always_comb begin
    baseAddr = ctl.isWrite ? dstReg : srcReg;
    if (xferWord) baseAddr[0] = ctl.subIdx;
    addr     = ctl.active ? baseAddr : '0;
    curWide  = ctl.isWrite ? dstWide : srcWide;
    oddByte  = baseAddr[0];
  end

  // Byte lane picked for a byte read
  always_comb begin
    if (curWide && oddByte) readByte = rdData[7:0];
    else                    readByte = rdData[15:8];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcReg   <= '0;
      dstReg   <= '0;
      xferWord <= 1'b0;
      dataBuf  <= '0;
    end else begin
      if (ctl.latchReq) begin
        srcReg   <= reqSrc;
        dstReg   <= reqDst;
        xferWord <= reqWord;
      end
      if (ctl.capture) begin
        if (xferWord && srcWide)  dataBuf <= rdData;
        else if (!xferWord)       dataBuf[7:0] <= readByte;
        else if (!ctl.subIdx)     dataBuf[15:8] <= rdData[15:8];
        else                      dataBuf[7:0] <= rdData[15:8];
      end
    end
  end

  always_comb begin
    if (xferWord && !ctl.subIdx) writeByte = dataBuf[15:8];
    else                         writeByte = dataBuf[7:0];
    wrData    = (xferWord && dstWide) ? dataBuf : {writeByte, writeByte};
    rdStrobe  = ctl.strobe && !ctl.isWrite;
    hwrStrobe = ctl.strobe && ctl.isWrite && (!dstWide || xferWord || !oddByte);
    lwrStrobe = ctl.strobe && ctl.isWrite && dstWide && (xferWord || oddByte);
  end

endmodule

// File: rtl/dmaBusSeq.sv
module dmaBusSeq
  import dmaSeqPkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int AREA_BITS = 3,
  localparam int NUM_AREAS = 1 << AREA_BITS
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [ADDR_W-1:0]    reqSrc,
  input  logic [ADDR_W-1:0]    reqDst,
  input  logic                 reqWord,
  input  logic                 busGrant,
  input  logic [NUM_AREAS-1:0] areaWide,
  input  logic [NUM_AREAS-1:0] areaThree,
  input  logic [15:0]          rdData,
  output logic                 busHold,
  output logic [ADDR_W-1:0]    addr,
  output logic                 rdStrobe,
  output logic                 hwrStrobe,
  output logic                 lwrStrobe,
  output logic [15:0]          wrData,
  output logic                 done
);

  seqCtl_t ctl;
  logic xferWord, srcWide, srcThree, dstWide, dstThree;

  dmaSeqCtrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .busGrant (busGrant),
    .xferWord (xferWord),
    .srcWide  (srcWide),
    .srcThree (srcThree),
    .dstWide  (dstWide),
    .dstThree (dstThree),
    .ctl      (ctl),
    .busHold  (busHold),
    .done     (done)
  );

  dmaSeqPath #(.ADDR_W(ADDR_W), .AREA_BITS(AREA_BITS)) i_path (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .reqSrc    (reqSrc),
    .reqDst    (reqDst),
    .reqWord   (reqWord),
    .areaWide  (areaWide),
    .areaThree (areaThree),
    .rdData    (rdData),
    .xferWord  (xferWord),
    .srcWide   (srcWide),
    .srcThree  (srcThree),
    .dstWide   (dstWide),
    .dstThree  (dstThree),
    .addr      (addr),
    .rdStrobe  (rdStrobe),
    .hwrStrobe (hwrStrobe),
    .lwrStrobe (lwrStrobe),
    .wrData    (wrData)
  );

endmodule

// File: rtl/dmaBusSeqChk.sv
module dmaBusSeqChk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              busHold,
  input logic [ADDR_W-1:0] addr,
  input logic              rdStrobe,
  input logic              hwrStrobe,
  input logic              lwrStrobe,
  input logic              done
);

  logic anyStrobe;
  assign anyStrobe = rdStrobe || hwrStrobe || lwrStrobe;

  // R8: a strobe is only ever driven while the bus is held
  assert_strobe_held_R8: assert property (@(posedge clk) disable iff (!rstN)
    anyStrobe |-> busHold);

  // R2: the first held cycle is a dead cycle
  assert_dead_cycle_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busHold) |-> !anyStrobe);

  // R2: the cycle after the dead cycle is T1, which has no strobe
  assert_first_t1_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busHold) |=> (busHold && !anyStrobe));

  // R9: busHold is released only together with done
  assert_release_done_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busHold) |-> done);

  // R9: done lasts a single cycle and comes with busHold low
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busHold ##1 !done));

  // R11: read and write strobes are mutually exclusive
  assert_rw_exclusive_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(rdStrobe && (hwrStrobe || lwrStrobe)));

  // R11: the address holds steady while a strobe is active
  assert_addr_stable_R11: assert property (@(posedge clk) disable iff (!rstN)
    anyStrobe |-> $stable(addr));

endmodule

bind dmaBusSeq dmaBusSeqChk #(.ADDR_W(ADDR_W)) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busHold   (busHold),
  .addr      (addr),
  .rdStrobe  (rdStrobe),
  .hwrStrobe (hwrStrobe),
  .lwrStrobe (lwrStrobe),
  .done      (done)
);

// File: tb/test_dmaBusSeq.sv
`timescale 1ns/1ps
module test_dmaBusSeq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [23:0] reqSrc = '0;
  logic [23:0] reqDst = '0;
  logic        reqWord = 1'b0;
  logic        busGrant = 1'b0;
  logic [7:0]  areaWide  = 8'b0101_0011;
  logic [7:0]  areaThree = 8'b0110_1010;
  logic [15:0] rdData;
  logic        busHold, rdStrobe, hwrStrobe, lwrStrobe, done;
  logic [23:0] addr;
  logic [15:0] wrData;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  dmaBusSeq i_dmaBusSeq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqSrc(reqSrc),
    .reqDst(reqDst), .reqWord(reqWord), .busGrant(busGrant),
    .areaWide(areaWide), .areaThree(areaThree), .rdData(rdData),
    .busHold(busHold), .addr(addr), .rdStrobe(rdStrobe),
    .hwrStrobe(hwrStrobe), .lwrStrobe(lwrStrobe), .wrData(wrData),
    .done(done)
  );

  function automatic logic [7:0] memByte(input logic [23:0] a);
    return a[7:0] ^ {a[15:12], a[19:16]} ^ 8'hA5;
  endfunction

  // Bus memory model: 16-bit areas return both bytes, 8-bit areas use [15:8]
  always_comb begin
    if (areaWide[addr[23:21]])
      rdData = {memByte({addr[23:1], 1'b0}), memByte({addr[23:1], 1'b1})};
    else
      rdData = {memByte(addr), 8'h3C};
  end

  // Expected per-cycle trace
  logic [23:0] expAddr [0:15];
  logic        expRd   [0:15];
  logic        expHwr  [0:15];
  logic        expLwr  [0:15];
  logic [15:0] expWd   [0:15];
  string       expTag  [0:15];
  int          nExp;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  task automatic addCyc(input logic [23:0] a, input bit isWr, input bit three,
                        input bit h, input bit l, input logic [15:0] wd,
                        input string tag);
    int n = three ? 3 : 2;
    for (int s = 0; s < n; s++) begin
      expAddr[nExp] = a;
      expRd[nExp]   = !isWr && (s > 0);
      expHwr[nExp]  = isWr && (s > 0) && h;
      expLwr[nExp]  = isWr && (s > 0) && l;
      expWd[nExp]   = wd;
      expTag[nExp]  = tag;
      nExp++;
    end
  endtask

  task automatic buildTrace(input logic [23:0] src, input logic [23:0] dst,
                            input bit word);
    bit wS = areaWide[src[23:21]];
    bit tS = areaThree[src[23:21]];
    bit wD = areaWide[dst[23:21]];
    bit tD = areaThree[dst[23:21]];
    logic [23:0] sE = {src[23:1], 1'b0};
    logic [23:0] dE = {dst[23:1], 1'b0};
    logic [7:0] hi = memByte(sE);
    logic [7:0] lo = memByte({src[23:1], 1'b1});
    logic [7:0] b  = memByte(src);
    nExp = 0;
    if (word) begin
      if (wS) addCyc(sE, 0, tS, 0, 0, 16'h0, "R5");
      else begin
        addCyc(sE, 0, tS, 0, 0, 16'h0, "R6");
        addCyc({src[23:1], 1'b1}, 0, tS, 0, 0, 16'h0, "R6");
      end
      if (wD) addCyc(dE, 1, tD, 1, 1, {hi, lo}, "R5");
      else begin
        addCyc(dE, 1, tD, 1, 0, {hi, 8'h0}, "R6");
        addCyc({dst[23:1], 1'b1}, 1, tD, 1, 0, {lo, 8'h0}, "R6");
      end
    end else begin
      addCyc(src, 0, tS, 0, 0, 16'h0, "R7");
      if (wD) addCyc(dst, 1, tD, !dst[0], dst[0], {b, b}, "R7");
      else    addCyc(dst, 1, tD, 1, 0, {b, 8'h0}, "R7");
    end
  endtask

  task automatic doXfer(input logic [23:0] src, input logic [23:0] dst,
                        input bit word, input bit dropGrant);
    buildTrace(src, dst, word);
    @(negedge clk);
    reqSrc = src; reqDst = dst; reqWord = word;
    reqValid = 1'b1; busGrant = 1'b1;
    @(posedge clk); @(negedge clk);
    reqValid = 1'b0;
    // R2: dead cycle
    check(busHold && !rdStrobe && !hwrStrobe && !lwrStrobe, "R2", "dead cycle",
          {busHold, rdStrobe, hwrStrobe, lwrStrobe}, 4'b1000);
    if (dropGrant) busGrant = 1'b0;
    for (int i = 0; i < nExp; i++) begin
      @(posedge clk); @(negedge clk);
      check(busHold, "R8", "busHold during access", busHold, 1);
      check(addr == expAddr[i], expTag[i], "address", addr, expAddr[i]);
      check(rdStrobe == expRd[i], "R3", "read strobe", rdStrobe, expRd[i]);
      check(hwrStrobe == expHwr[i] && lwrStrobe == expLwr[i], "R11",
            "write strobes", {hwrStrobe, lwrStrobe}, {expHwr[i], expLwr[i]});
      if (expHwr[i])
        check(wrData[15:8] == expWd[i][15:8], expTag[i], "high lane data",
              wrData[15:8], expWd[i][15:8]);
      if (expLwr[i])
        check(wrData[7:0] == expWd[i][7:0], expTag[i], "low lane data",
              wrData[7:0], expWd[i][7:0]);
    end
    @(posedge clk); @(negedge clk);
    check(done && !busHold, "R9", "completion", {done, busHold}, 2'b10);
    reqValid = 1'b1;
    @(posedge clk); @(negedge clk);
    check(!done, "R9", "done width", done, 0);
    if (!dropGrant) begin
      // R10: grant still high, request must be ignored
      for (int k = 0; k < 3; k++) begin
        @(posedge clk); @(negedge clk);
        check(!busHold && !rdStrobe, "R10", "request ignored without regrant",
              {busHold, rdStrobe}, 2'b00);
      end
    end
    reqValid = 1'b0;
    busGrant = 1'b0;
    @(posedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        $display("FAIL R9 watchdog expired: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!busHold && !done && !rdStrobe && !hwrStrobe && !lwrStrobe && addr == 0,
          "R1", "reset state", {busHold, done, rdStrobe, hwrStrobe, lwrStrobe}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busHold && !done && addr == 0, "R1", "after reset", {busHold, done}, 0);

    // R4: directed word from area 0 (16-bit, two-state) to area 3 (8-bit, three-state)
    doXfer(24'h012344, 24'h6ABCD0, 1'b1, 1'b0);
    // R4: reversed, area 3 to area 0
    doXfer(24'h6ABCD2, 24'h012346, 1'b1, 1'b0);
    // R7: byte transfers on odd and even lanes of 16-bit areas
    doXfer(24'h200011, 24'h012340, 1'b0, 1'b0);
    doXfer(24'h012342, 24'h200013, 1'b0, 1'b0);
    // R8: grant dropped during the transfer
    doXfer(24'hE00100, 24'h400201, 1'b1, 1'b1);

    for (int n = 0; n < 60; n++) begin
      logic [23:0] s = $urandom();
      logic [23:0] d = $urandom();
      bit w = $urandom_range(0, 1);
      bit g = $urandom_range(0, 1);
      doXfer(s, d, w, g);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule